// File: doc/BRIEF.md
# Multiplexed Display Refresh Controller

This block keeps one byte of segment data for each of sixteen display blocks and refreshes the display from that store without pause. A fast host loads the store by raising a transfer strobe and presenting a block index and a segment byte. While the strobe is low, a slow scan takes over the store's address port. The scan advances only on a clock-enable tick, which stands in for the slow refresh clock.

The scan counter is rotated left by one bit to form the block index. Successive steps therefore land on blocks that are never physical neighbours: the even-indexed blocks come first, then the odd-indexed ones.

Each scan step lasts two ticks. On the first tick the anode moves to the new block while every segment line is held low, which gives a refresh gap. On the second tick that block's stored byte is driven onto the cathode lines. While the host strobe is high, the segment lines are forced low and the scan freezes, so partly written data is never shown.

Top module: `seg_scan_refresh`

## Requirements
- R1: After reset, `anode` and `cathode` are all zero, the scan counter is 0, the scan waits in its gap phase, and every stored byte is 0.
- R2: On each clock edge where `host_xfer` is 1, `host_data` is stored at block index `host_addr`. A later data tick for that block shows the new byte.
- R3: While `host_xfer` is 1, `cathode` is 0 from the following cycle on. `anode`, the scan counter and the phase hold their values, and a `scan_tick` that arrives during a transfer is ignored.
- R4: A scan step takes two ticks. The gap tick sets `anode` to the step's block and `cathode` to 0. The data tick drives that block's stored byte onto `cathode`, leaves `anode` unchanged and advances the counter.
- R5: For scan counter value k (bits k3..k0), the block index is {k2,k1,k0,k3}. For example, k=0 gives 0, k=1 gives 2, k=7 gives 14, k=8 gives 1 and k=15 gives 15.
- R6: `anode` is one-hot or zero, and bit n selects block index n.
- R7: Two blocks selected one after the other are never adjacent, that is, their indices never differ by exactly 1.
- R8: The counter wraps from 15 to 0, so the scan repeats every 16 steps (32 ticks).
- R9: When there is no tick and no transfer, `anode` and `cathode` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scan_tick | input | 1 | One-cycle enable that advances the refresh scan |
| host_xfer | input | 1 | Host transfer strobe; when 1, the store is written |
| host_addr | input | 4 | Block index for a host write |
| host_data | input | 8 | Segment byte for a host write |
| anode | output | 16 | One-hot block select |
| cathode | output | 8 | Segment lines |

## Verification
A host write and a scan tick can land on the same clock edge. Only one of them may use the store's address port, and only one may decide the cathode value. The bench raises `scan_tick` in the same cycle as a `host_xfer` that rewrites the block currently on display, partway through a step. The collision is judged correct if `anode` has not moved, `cathode` has gone to zero, and the next ordinary tick shows the newly written byte for that same block rather than moving on to the next step.

// File: rtl/seg_scan_refresh.sv
module seg_scan_refresh #(
  parameter int ADDR_W = 4,
  parameter int SEG_W  = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      scan_tick,
  input  logic                      host_xfer,
  input  logic [ADDR_W-1:0]         host_addr,
  input  logic [SEG_W-1:0]          host_data,
  output logic [(1<<ADDR_W)-1:0]    anode,
  output logic [SEG_W-1:0]          cathode
);
  localparam int NBLK = 1 << ADDR_W;

  logic [SEG_W-1:0]  store [NBLK];
  logic [ADDR_W-1:0] cnt;
  logic              show;

  // R5: rotate the counter left by one to get the block index
  wire [ADDR_W-1:0] scan_idx = {cnt[ADDR_W-2:0], cnt[ADDR_W-1]};
  wire [ADDR_W-1:0] ram_addr = host_xfer ? host_addr : scan_idx;
  wire [NBLK-1:0]   sel_hot  = {{(NBLK-1){1'b0}}, 1'b1} << scan_idx;

  // R1, R2: the store is written only while the transfer strobe is high
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NBLK; i++) store[i] <= '0;
    end else if (host_xfer) begin
      store[ram_addr] <= host_data;
    end
  end

  // R3, R4, R8, R9: two-phase scan step
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      show    <= 1'b0;
      anode   <= '0;
      cathode <= '0;
    end else if (host_xfer) begin
      cathode <= '0;
    end else if (scan_tick) begin
      if (!show) begin
        anode   <= sel_hot;
        cathode <= '0;
        show    <= 1'b1;
      end else begin
        cathode <= store[ram_addr];
        show    <= 1'b0;
        cnt     <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/seg_scan_refresh_chk.sv
module seg_scan_refresh_chk #(
  parameter int ADDR_W = 4,
  parameter int SEG_W  = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   scan_tick,
  input logic                   host_xfer,
  input logic [(1<<ADDR_W)-1:0] anode,
  input logic [SEG_W-1:0]       cathode
);
  AST_ANODE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(anode)); // R6

  AST_XFER_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    host_xfer |=> (cathode == '0)); // R3

  AST_XFER_ANODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    host_xfer |=> $stable(anode)); // R3

  AST_GAP_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(anode) |-> (cathode == '0)); // R4

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!scan_tick && !host_xfer) |=> ($stable(anode) && $stable(cathode))); // R9

  AST_NO_NEIGHBOUR: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(anode) && $past(anode) != '0) |->
      (((anode & ($past(anode) << 1)) == '0) &&
       ((anode & ($past(anode) >> 1)) == '0))); // R7
endmodule

bind seg_scan_refresh seg_scan_refresh_chk #(.ADDR_W(ADDR_W), .SEG_W(SEG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .scan_tick(scan_tick), .host_xfer(host_xfer),
  .anode(anode), .cathode(cathode));

// File: tb/seg_scan_refresh_tb.sv
module seg_scan_refresh_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scan_tick = 1'b0;
  logic        host_xfer = 1'b0;
  logic [3:0]  host_addr = '0;
  logic [7:0]  host_data = '0;
  logic [15:0] anode;
  logic [7:0]  cathode;

  int checks = 0;
  int fails  = 0;
  logic [7:0] model [16];
  int cnt_m = 0;
  int prev_blk = -1;

  seg_scan_refresh u_dut (.*);

  always #5 clk = ~clk;

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int blk_of(input int k);
    return ((k << 1) & 14) | ((k >> 3) & 1);
  endfunction

  task automatic tick();
    @(negedge clk) scan_tick = 1'b1;
    @(negedge clk) scan_tick = 1'b0;
  endtask

  task automatic write(input int a, input int d);
    @(negedge clk) begin host_xfer = 1'b1; host_addr = 4'(a); host_data = 8'(d); end
    @(negedge clk) host_xfer = 1'b0;
    model[a] = 8'(d);
  endtask

  // One scan step: the gap tick, then the data tick
  task automatic step();
    int b;
    b = blk_of(cnt_m);
    tick();
    chk("R4 gap anode", anode, 64'(16'h1 << b));
    chk("R4 gap cathode", cathode, 0);
    if (prev_blk >= 0) chk("R7 not adjacent", (b == prev_blk + 1 || b == prev_blk - 1), 0);
    repeat (3) @(negedge clk);
    chk("R9 hold anode", anode, 64'(16'h1 << b));
    tick();
    chk("R4 data cathode", cathode, model[b]);
    chk("R6 anode bit", anode, 64'(16'h1 << b));
    prev_blk = b;
    cnt_m = (cnt_m + 1) % 16;
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk("R1 anode reset", anode, 0);
    chk("R1 cathode reset", cathode, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 anode idle", anode, 0);
    chk("R5 k=1 -> 2", blk_of(1), 2);
    chk("R5 k=8 -> 1", blk_of(8), 1);
    chk("R5 k=7 -> 14", blk_of(7), 14);
    // R1: a full scan shows zeros everywhere
    for (int s = 0; s < 16; s++) step();
    // R2: load every block
    for (int i = 0; i < 16; i++) write(i, (i * 37 + 5) & 8'hff);
    chk("R3 cathode after xfer", cathode, 0);
    // R8: two full scans, wrapping 15 -> 0
    for (int s = 0; s < 32; s++) step();
    chk("R8 wrapped counter", cnt_m, 0);
    // Collision: a tick during a host write to the block on display
    tick();
    begin
      int b;
      logic [15:0] an_before;
      b = blk_of(cnt_m);
      an_before = anode;
      @(negedge clk) begin host_xfer = 1'b1; scan_tick = 1'b1;
        host_addr = 4'(b); host_data = 8'hA5; end
      @(negedge clk) begin host_xfer = 1'b0; scan_tick = 1'b0; end
      model[b] = 8'hA5;
      chk("R3 anode held", anode, an_before);
      chk("R3 cathode blanked", cathode, 0);
      tick();
      chk("R2 new byte shown", cathode, 8'hA5);
      chk("R3 tick ignored, same block", anode, an_before);
      prev_blk = b;
      cnt_m = (cnt_m + 1) % 16;
    end
    for (int s = 0; s < 16; s++) step();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule